// File: doc/BRIEF.md
# Wired-OR Bus Arbitration Controller

This block lets one device on a shared parallel bus claim ownership through priority contention. It watches the sampled busy and select lines, the bus reset line and an 8-bit wired-OR data bus. Once both control lines have been quiet for a settle window, it may enter contention. To contend, it drives busy together with its own one-hot ID bit. After an arbitration window it reads the data bus, where bit 7 has the highest priority. It then either takes the bus by driving select, or backs off.

A request is latched from a one-cycle pulse. If the device loses, it retries on its own at the next bus-free interval, until it either wins or the request is dropped. Every bus timing is a parameter counted in clock cycles: settle, free, set, arbitration and clear. The outputs are drive enables for an external open-collector stage, plus single-cycle won and lost pulses. The parity line is not an output, so it is never driven low. After a win the controller keeps busy, select and its ID bit driven until the request is dropped or a bus reset occurs. A later selection stage takes over from that point.

Top module: `arb_contender`

## Requirements
- R1: The bus counts as free only after SETTLE_CYC consecutive clock samples with busy, select and bus reset all low. Any single sample with one of them high restarts the count from zero.
- R2: With a request pending, busy drive begins at the rising edge that comes SETTLE_CYC+FREE_CYC+1 edges after the first quiet sample. The bus must still be quiet at that edge.
- R3: Contention is not entered once more than SET_CYC cycles have passed since free was detected. A request that arrives later waits for the bus to go busy and become free again.
- R4: While contending, the block drives busy and exactly one data bit, which is the ID bit latched with the request. It releases select and the other seven data bits. Data bits are never driven without busy.
- R5: The decision is taken ARB_CYC cycles after busy is first driven. If any data bit above its own ID bit is set, the device loses; bit 7 is the highest priority. Otherwise the device wins and drives select from the next cycle.
- R6: A winner holds busy, select and its ID bit for CLEAR_CYC+SETTLE_CYC cycles after select rises. It then pulses won_o for one cycle and keeps driving until dropped or reset.
- R7: A loss releases all lines in the cycle after the decision and pulses lost_o for one cycle. A loss is either a higher ID bit at the decision, or a foreign select seen at any point during contention.
- R8: Bus reset high at a clock edge releases every drive enable from that edge on, and the controller returns to waiting for a free bus.
- R9: A request whose ID does not have exactly one bit set is ignored and not latched.
- R10: A latched request stays pending after a loss and is retried automatically. It is cleared by a win or by a drop.
- R11: Drop high at an edge releases all lines from that edge on without a won or lost pulse, and clears the pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_busy_i | input | 1 | Sampled busy line (wired-OR of all devices) |
| bus_sel_i | input | 1 | Sampled select line |
| bus_rst_i | input | 1 | Sampled bus reset line |
| bus_data_i | input | 8 | Sampled wired-OR data bus |
| arb_req_i | input | 1 | One-cycle pulse that latches a request and the ID |
| arb_drop_i | input | 1 | Cancel a pending request or release an owned bus |
| my_id_i | input | 8 | Own one-hot device ID |
| busy_drive_o | output | 1 | Drive enable for the busy line |
| sel_drive_o | output | 1 | Drive enable for the select line |
| data_drive_o | output | 8 | Drive enables for the data bits |
| won_o | output | 1 | One-cycle pulse: ownership taken |
| lost_o | output | 1 | One-cycle pulse: contention lost |

## Verification
The assertions check the following on every cycle:
- free is never reported without a quiet sample behind it;
- busy only rises out of a quiet bus;
- at most one data bit is driven, and only together with busy;
- select only rises while busy is already driven;
- won_o never appears before select has been held for the full hold window;
- a lost pulse or a bus reset always leaves the lines released.

Some behaviour only the bench scenarios can show: the exact cycle of entry, the choice of winner against a set of competitors, the late-request window, the restart after a glitch, and the automatic retry after a loss. The bench computes these against randomly drawn IDs and competitor sets as well as directed boundary cases.

// File: rtl/arbc_pkg.sv
package arbc_pkg;

  typedef enum logic [2:0] {
    ST_WAIT    = 3'd0,
    ST_ARB     = 3'd1,
    ST_LOSE    = 3'd2,
    ST_SELHOLD = 3'd3,
    ST_GRANT   = 3'd4,
    ST_OWN     = 3'd5
  } arb_state_t;

endpackage

// File: rtl/arbc_idle_watch.sv
module arbc_idle_watch #(
  parameter int SETTLE_CYC = 4,
  parameter int FREE_CYC   = 3,
  parameter int SET_CYC    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_busy_i,
  input  logic bus_sel_i,
  input  logic bus_rst_i,
  output logic bus_free_o,
  output logic window_o
);

  localparam int QW = $clog2(SETTLE_CYC + 1) + 1;
  localparam int AW = $clog2(SET_CYC + 2) + 1;
  localparam logic [QW-1:0] Q_FULL   = QW'(SETTLE_CYC);
  localparam logic [AW-1:0] AGE_OPEN = AW'(FREE_CYC);
  localparam logic [AW-1:0] AGE_SHUT = AW'(SET_CYC);

  logic          quiet;
  logic [QW-1:0] qcnt_q, qcnt_d;
  logic [AW-1:0] age_q, age_d;

  assign quiet = !bus_busy_i && !bus_sel_i && !bus_rst_i;

  // consecutive quiet-sample counter, saturating at the settle window
  always_comb begin
    qcnt_d = qcnt_q;
    if (!quiet) begin
      qcnt_d = '0;
    end else if (qcnt_q < Q_FULL) begin
      qcnt_d = qcnt_q + 1'b1;
    end
  end

  assign bus_free_o = (qcnt_q == Q_FULL);

  // cycles since free was detected, saturating just past the set window
  always_comb begin
    age_d = age_q;
    if (!bus_free_o) begin
      age_d = '0;
    end else if (age_q <= AGE_SHUT) begin
      age_d = age_q + 1'b1;
    end
  end

  assign window_o = bus_free_o && quiet && (age_q >= AGE_OPEN) && (age_q <= AGE_SHUT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qcnt_q <= '0;
      age_q  <= '0;
    end else begin
      qcnt_q <= qcnt_d;
      age_q  <= age_d;
    end
  end

  // R1: free is only reported when the previous sample was quiet
  a_r1_free_needs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    bus_free_o |-> $past(quiet));

endmodule

// File: rtl/arbc_prio_cmp.sv
module arbc_prio_cmp #(
  parameter int ID_W = 8
) (
  input  logic [ID_W-1:0] cand_id_i,
  input  logic [ID_W-1:0] bus_data_i,
  input  logic [ID_W-1:0] new_id_i,
  output logic            higher_o,
  output logic            id_ok_o
);

  localparam int OW = $clog2(ID_W + 1);

  logic [ID_W-1:0] above;
  logic [OW-1:0]   ones;

  // above[i] is set when bit i outranks the candidate ID
  generate
    for (genvar gi = 0; gi < ID_W; gi++) begin : g_rank
      if (gi == 0) begin : g_low
        assign above[gi] = 1'b0;
      end else begin : g_up
        assign above[gi] = |cand_id_i[gi-1:0];
      end
    end
  endgenerate

  assign higher_o = |(bus_data_i & above);

  always_comb begin
    ones = '0;
    for (int i = 0; i < ID_W; i++) begin
      ones = ones + OW'(new_id_i[i]);
    end
  end

  assign id_ok_o = (ones == OW'(1));

endmodule

// File: rtl/arbc_fsm.sv
module arbc_fsm
  import arbc_pkg::*;
#(
  parameter int ID_W     = 8,
  parameter int ARB_CYC  = 5,
  parameter int HOLD_CYC = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            window_i,
  input  logic            sel_line_i,
  input  logic            bus_rst_i,
  input  logic            higher_i,
  input  logic            id_ok_i,
  input  logic            req_i,
  input  logic            drop_i,
  input  logic [ID_W-1:0] id_i,
  output logic [ID_W-1:0] cand_id_o,
  output logic            drive_bsy_o,
  output logic            drive_sel_o,
  output logic [ID_W-1:0] drive_data_o,
  output logic            won_o,
  output logic            lost_o
);

  localparam int CMAX  = (ARB_CYC > HOLD_CYC) ? ARB_CYC : HOLD_CYC;
  localparam int CNT_W = $clog2(CMAX + 1);
  localparam logic [CNT_W-1:0] ARB_LAST  = CNT_W'(ARB_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);

  arb_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic [ID_W-1:0]  id_q;
  logic             id_en;

  // next-state
  always_comb begin
    state_d = state_q;
    cnt_d   = '0;
    unique case (state_q)
      ST_WAIT: begin
        if (pend_q && window_i) state_d = ST_ARB;
      end
      ST_ARB: begin
        if (sel_line_i) begin
          state_d = ST_LOSE;
        end else if (cnt_q == ARB_LAST) begin
          state_d = higher_i ? ST_LOSE : ST_SELHOLD;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_LOSE: state_d = ST_WAIT;
      ST_SELHOLD: begin
        if (cnt_q == HOLD_LAST) state_d = ST_GRANT;
        else                    cnt_d   = cnt_q + 1'b1;
      end
      ST_GRANT: state_d = ST_OWN;
      ST_OWN:   state_d = ST_OWN;
      default:  state_d = ST_WAIT;
    endcase
    if (bus_rst_i || drop_i) begin
      state_d = ST_WAIT;
      cnt_d   = '0;
    end
  end

  // request latch: drop wins, a new valid request sets, a grant consumes
  always_comb begin
    pend_d = pend_q;
    if (state_q == ST_GRANT) pend_d = 1'b0;
    if (req_i && id_ok_i)    pend_d = 1'b1;
    if (drop_i)              pend_d = 1'b0;
  end

  assign id_en = req_i && id_ok_i && !drop_i && (state_q == ST_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      id_q    <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pend_q  <= pend_d;
      if (id_en) id_q <= id_i;
    end
  end

  assign cand_id_o    = id_q;
  assign drive_bsy_o  = (state_q != ST_WAIT) && (state_q != ST_LOSE);
  assign drive_sel_o  = (state_q == ST_SELHOLD) || (state_q == ST_GRANT) || (state_q == ST_OWN);
  assign drive_data_o = drive_bsy_o ? id_q : '0;
  assign won_o        = (state_q == ST_GRANT);
  assign lost_o       = (state_q == ST_LOSE);

  // R9: an ID that is not one-hot never becomes pending on its own
  a_r9_bad_id_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && req_i && !id_ok_i) |=> !pend_q);

  // R10: a loss keeps the request pending unless it was dropped
  a_r10_retry_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOSE && !drop_i) |=> pend_q);

endmodule

// File: rtl/arb_contender.sv
module arb_contender #(
  parameter int ID_W       = 8,
  parameter int SETTLE_CYC = 4,
  parameter int FREE_CYC   = 3,
  parameter int SET_CYC    = 8,
  parameter int ARB_CYC    = 5,
  parameter int CLEAR_CYC  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_busy_i,
  input  logic            bus_sel_i,
  input  logic            bus_rst_i,
  input  logic [ID_W-1:0] bus_data_i,
  input  logic            arb_req_i,
  input  logic            arb_drop_i,
  input  logic [ID_W-1:0] my_id_i,
  output logic            busy_drive_o,
  output logic            sel_drive_o,
  output logic [ID_W-1:0] data_drive_o,
  output logic            won_o,
  output logic            lost_o
);

  localparam int HOLD_CYC = CLEAR_CYC + SETTLE_CYC;
  localparam int HW       = $clog2(HOLD_CYC + 1) + 1;

  logic [1:0]      rst_sync;
  logic            rst_n_s;
  logic            free_w, window_w, higher_w, id_ok_w;
  logic [ID_W-1:0] cand_id_w;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  arbc_idle_watch #(
    .SETTLE_CYC(SETTLE_CYC),
    .FREE_CYC  (FREE_CYC),
    .SET_CYC   (SET_CYC)
  ) u_idle (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .bus_busy_i(bus_busy_i),
    .bus_sel_i (bus_sel_i),
    .bus_rst_i (bus_rst_i),
    .bus_free_o(free_w),
    .window_o  (window_w)
  );

  arbc_prio_cmp #(.ID_W(ID_W)) u_prio (
    .cand_id_i (cand_id_w),
    .bus_data_i(bus_data_i),
    .new_id_i  (my_id_i),
    .higher_o  (higher_w),
    .id_ok_o   (id_ok_w)
  );

  arbc_fsm #(
    .ID_W    (ID_W),
    .ARB_CYC (ARB_CYC),
    .HOLD_CYC(HOLD_CYC)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .window_i    (window_w),
    .sel_line_i  (bus_sel_i),
    .bus_rst_i   (bus_rst_i),
    .higher_i    (higher_w),
    .id_ok_i     (id_ok_w),
    .req_i       (arb_req_i),
    .drop_i      (arb_drop_i),
    .id_i        (my_id_i),
    .cand_id_o   (cand_id_w),
    .drive_bsy_o (busy_drive_o),
    .drive_sel_o (sel_drive_o),
    .drive_data_o(data_drive_o),
    .won_o       (won_o),
    .lost_o      (lost_o)
  );

  // checker-only counter: consecutive cycles with select driven
  logic [HW-1:0] sel_run;
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)                      sel_run <= '0;
    else if (!sel_drive_o)             sel_run <= '0;
    else if (sel_run < HW'(HOLD_CYC))  sel_run <= sel_run + 1'b1;
  end

  // R2: busy is only taken out of a quiet bus
  a_r2_enter_quiet: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(busy_drive_o) |-> $past(!bus_busy_i && !bus_sel_i && !bus_rst_i));

  // R4: at most one data bit, and data only together with busy
  a_r4_one_bit: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0(data_drive_o) && ((|data_drive_o) == busy_drive_o));

  // R5: select only rises while busy is already held
  a_r5_sel_after_busy: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(sel_drive_o) |-> $past(busy_drive_o));

  // R6: won only after the full hold window with select driven
  a_r6_hold_before_won: assert property (@(posedge clk) disable iff (!rst_n_s)
    won_o |-> (sel_run >= HW'(HOLD_CYC)) && !lost_o);

  // R7: a lost pulse comes with every line released
  a_r7_lost_released: assert property (@(posedge clk) disable iff (!rst_n_s)
    lost_o |-> (!busy_drive_o && !sel_drive_o && (data_drive_o == '0)));

  // R8: bus reset releases everything at the next cycle
  a_r8_rst_release: assert property (@(posedge clk) disable iff (!rst_n_s)
    bus_rst_i |=> (!busy_drive_o && !sel_drive_o && (data_drive_o == '0)));

  // R11: drop releases everything with no pulse
  a_r11_drop_release: assert property (@(posedge clk) disable iff (!rst_n_s)
    arb_drop_i |=> (!busy_drive_o && !sel_drive_o && !won_o && !lost_o));

endmodule

// File: tb/arb_contender_test.sv
`timescale 1ns/1ps
module arb_contender_test;

  localparam int S    = 4;
  localparam int F    = 3;
  localparam int SETW = 8;
  localparam int A    = 5;
  localparam int C    = 2;
  localparam int HOLD = C + S;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_bsy = 1'b1, ext_sel = 1'b0, bus_rst = 1'b0;
  logic       req = 1'b0, drop = 1'b0;
  logic [7:0] ext_data = 8'h00, my_id = 8'h01;
  logic       busy_drive_o, sel_drive_o, won_o, lost_o;
  logic [7:0] data_drive_o;
  wire        bsy_line = busy_drive_o | ext_bsy;
  wire        sel_line = sel_drive_o | ext_sel;
  wire [7:0]  data_line = data_drive_o | ext_data;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  arb_contender #(
    .ID_W(8), .SETTLE_CYC(S), .FREE_CYC(F), .SET_CYC(SETW), .ARB_CYC(A), .CLEAR_CYC(C)
  ) uut (
    .clk(clk), .rst_n(rst_n),
    .bus_busy_i(bsy_line), .bus_sel_i(sel_line), .bus_rst_i(bus_rst),
    .bus_data_i(data_line), .arb_req_i(req), .arb_drop_i(drop), .my_id_i(my_id),
    .busy_drive_o(busy_drive_o), .sel_drive_o(sel_drive_o), .data_drive_o(data_drive_o),
    .won_o(won_o), .lost_o(lost_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // win when no competitor bit sits above the own bit (bit 7 highest)
  function automatic bit exp_win(input logic [7:0] id, input logic [7:0] ext);
    logic [8:0] low;
    low = ({1'b0, id} << 1) - 9'd1;
    return ((ext & ~low[7:0]) == 8'h00);
  endfunction

  task automatic prep();
    ext_bsy = 1'b1; ext_sel = 1'b0; ext_data = 8'h00; bus_rst = 1'b0; req = 1'b0;
    drop = 1'b1;
    @(negedge clk); @(negedge clk);
    drop = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_busy(input int limit, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      req = 1'b0;
    end while (!busy_drive_o && n < limit);
  endtask

  task automatic no_busy_for(input int cyc, input string tag);
    int seen = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      req = 1'b0;
      if (busy_drive_o) seen++;
    end
    chk(seen == 0, tag, seen, 0);
  endtask

  task automatic round(input logic [7:0] id, input logic [7:0] ext);
    int n, m, k;
    bit w;
    prep();
    my_id = id; req = 1'b1; ext_bsy = 1'b0;
    wait_busy(60, n);
    chk(n == S + F + 1, "R2 entry cycle", n, S + F + 1);
    chk(data_drive_o == id, "R4 own bit only", data_drive_o, id);
    chk(!sel_drive_o, "R4 select released", sel_drive_o, 0);
    ext_data = ext; ext_bsy = (ext != 8'h00);
    m = 0;
    do begin
      @(negedge clk);
      m++;
    end while (!lost_o && !sel_drive_o && m < 40);
    w = exp_win(id, ext);
    chk(m == A, "R5 decision cycle", m, A);
    chk(sel_drive_o == w, "R5 outcome", sel_drive_o, w);
    if (w) begin
      k = 0;
      do begin
        @(negedge clk);
        k++;
      end while (!won_o && k < 40);
      chk(k == HOLD, "R6 won after hold", k, HOLD);
      chk(busy_drive_o && sel_drive_o && data_drive_o == id, "R6 lines held", data_drive_o, id);
      @(negedge clk);
      chk(!won_o && sel_drive_o, "R6 single pulse, still owned", won_o, 0);
    end else begin
      chk(lost_o && !busy_drive_o && data_drive_o == 8'h00, "R7 released on loss",
          data_drive_o, 0);
      ext_data = 8'h00; ext_bsy = 1'b0;
      wait_busy(60, n);
      chk(busy_drive_o, "R10 automatic retry", busy_drive_o, 1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy_drive_o && !sel_drive_o && data_drive_o == 8'h00 && !won_o && !lost_o,
        "R4 reset state released", data_drive_o, 0);

    // directed outcomes
    round(8'h80, 8'h7F);   // R5 top priority beats all lower
    round(8'h01, 8'h80);   // R5 lowest loses, R10 retry
    round(8'h08, 8'h07);   // R5 lower competitors only
    round(8'h10, 8'h20);   // R5 neighbour one above wins

    // R1: glitch on the last settle sample restarts the count
    prep();
    my_id = 8'h04; req = 1'b1; ext_bsy = 1'b0;
    repeat (S - 1) begin @(negedge clk); req = 1'b0; end
    ext_bsy = 1'b1;
    @(negedge clk);
    ext_bsy = 1'b0;
    wait_busy(60, n);
    chk(n == S + F + 1, "R1 glitch restarts settle", n, S + F + 1);

    // R3: a request after the set window waits for a fresh free interval
    prep();
    my_id = 8'h10; ext_bsy = 1'b0;
    repeat (S + SETW + 4) @(negedge clk);
    req = 1'b1;
    no_busy_for(30, "R3 no entry after set window");
    ext_bsy = 1'b1;
    @(negedge clk);
    ext_bsy = 1'b0;
    wait_busy(60, n);
    chk(n == S + F + 1, "R3 entry on fresh free", n, S + F + 1);

    // R7: foreign select during contention
    prep();
    my_id = 8'h02; req = 1'b1; ext_bsy = 1'b0;
    wait_busy(60, n);
    ext_sel = 1'b1;
    @(negedge clk);
    chk(lost_o && !busy_drive_o && data_drive_o == 8'h00, "R7 foreign select loses",
        lost_o, 1);
    ext_sel = 1'b0;

    // R8: bus reset while owning, R10 win clears request
    round(8'h40, 8'h00);
    bus_rst = 1'b1;
    @(negedge clk);
    chk(!busy_drive_o && !sel_drive_o && data_drive_o == 8'h00, "R8 reset releases",
        busy_drive_o, 0);
    bus_rst = 1'b0;
    no_busy_for(30, "R10 cleared by win");

    // R9: IDs that are not one-hot
    prep();
    my_id = 8'h05; req = 1'b1; ext_bsy = 1'b0;
    no_busy_for(40, "R9 two-bit ID ignored");
    prep();
    my_id = 8'h00; req = 1'b1; ext_bsy = 1'b0;
    no_busy_for(40, "R9 empty ID ignored");

    // R11: drop during contention
    prep();
    my_id = 8'h08; req = 1'b1; ext_bsy = 1'b0;
    wait_busy(60, n);
    drop = 1'b1;
    @(negedge clk);
    chk(!busy_drive_o && !lost_o && !won_o && data_drive_o == 8'h00, "R11 drop releases",
        busy_drive_o, 0);
    drop = 1'b0;
    no_busy_for(30, "R11 drop clears request");

    // random IDs against random competitor sets (R5)
    for (int it = 0; it < 16; it++) begin
      logic [7:0] id, ext;
      id  = 8'h01 << ($urandom % 8);
      ext = 8'($urandom) & ~id;
      round(id, ext);
    end

    prep();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule